// File: doc/BRIEF.md
# Selective Store Write Buffer

The block is a small ordered queue that sits between the core's store path and the next memory level. Each store arrives with a two-bit memory attribute. Only stores to cache-inhibited or write-through regions are posted into the queue. Stores to write-back regions are taken at once and never enter it, so they cost no queue space and produce no memory write. Posted stores leave in arrival order over a valid/ready write port, one per handshake. Each store keeps its address, data and byte enables intact.

The core can issue a synchronisation request that forces the queue to empty. While the request is outstanding, new posted stores are held off. A one-cycle acknowledge follows once nothing is left to write. A load whose address equals a queued store is stalled until that store has left, so no load can overtake a pending write.

Top module: `stwb_top`

## Requirements
- R1: The queue holds exactly DEPTH (default 4) posted stores. With the write port blocked, four eligible stores are taken without a stall and the fifth is stalled.
- R2: Only attribute 2'b01 (write-through) and 2'b10 (cache-inhibited) are posted. Attribute 2'b00 (write-back) and 2'b11 (reserved) are taken without a stall, even when the queue is full, and never cause a memory write.
- R3: Every write-through store produces exactly one memory write, even when several target the same address. Writes are never merged.
- R4: Memory writes leave in arrival order, each with the stored address, data and byte enables unchanged.
- R5: After a sync request, sync_ack pulses for one cycle only once every store taken before or with the request has been written out and the port shows no valid write. Eligible stores stall while the request is pending.
- R6: An eligible store presented while the queue is full and no write completes in that cycle sees st_stall high. It is taken later, never dropped.
- R7: When the queue is full and a write completes in the same cycle, an eligible store is taken in that cycle without overflow, and the queue stays full.
- R8: ld_stall is high in the same cycle as ld_valid when ld_addr equals the address of any queued store. It falls in the cycle after that store's write handshake.
- R9: After reset the queue is empty, mw_valid and sync_ack are low, and no load is stalled.
- R10: While mw_valid is high and mw_ready is low, mw_valid stays high and mw_addr, mw_data and mw_be stay unchanged.
- R11: A sync request made with an empty queue is acknowledged in the cycle right after the request edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store presented by the core |
| st_attr | input | 2 | Region attribute: 00 write-back, 01 write-through, 10 cache-inhibited, 11 reserved |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | BW | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle; hold it |
| ld_valid | input | 1 | Load presented by the core |
| ld_addr | input | AW | Load address |
| ld_stall | output | 1 | Load matches a queued store; hold it |
| sync_req | input | 1 | One-cycle request to drain the queue |
| sync_ack | output | 1 | One-cycle pulse: queue drained |
| mw_valid | output | 1 | Write to next-level memory is valid |
| mw_addr | output | AW | Write address |
| mw_data | output | DW | Write data |
| mw_be | output | BW | Write byte enables |
| mw_ready | input | 1 | Memory takes the write this cycle |

## Verification
st_stall and ld_stall are combinational and are due in the same cycle as the stimulus. A taken store can reach the write port one cycle after the edge that takes it. The write stays on the port until the edge where mw_ready is high. sync_ack appears in the cycle after the edge that removes the last queued store, or after the request edge when the queue is already empty. The bench drives every input on the falling edge and reads outputs a quarter period later, so each reading sees the settled value of the current cycle. The expected write list is updated at that same instant, when a store is taken or a write handshake is seen. A separate reading one time unit after the falling edge checks sync_ack against the expected list.

// File: rtl/stwb_pkg.sv
package stwb_pkg;

    typedef enum logic [1:0] {
        ATTR_WBACK    = 2'b00,
        ATTR_WTHRU    = 2'b01,
        ATTR_UNCACHED = 2'b10,
        ATTR_RSVD     = 2'b11
    } mem_attr_e;

    // Stores to these regions must reach next-level memory.
    function automatic logic attr_posted(input logic [1:0] attr);
        return (attr == ATTR_WTHRU) || (attr == ATTR_UNCACHED);
    endfunction

endpackage

// File: rtl/stwb_fifo.sv
module stwb_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              in_addr,
    input  logic [DW-1:0]              in_data,
    input  logic [BW-1:0]              in_be,
    input  logic                       pop,
    output logic                       out_valid,
    output logic [AW-1:0]              out_addr,
    output logic [DW-1:0]              out_data,
    output logic [BW-1:0]              out_be,
    output logic                       full,
    output logic                       empty,
    output logic                       empty_next,
    output logic [DEPTH-1:0]           slot_vld,
    output logic [DEPTH-1:0][AW-1:0]   slot_addr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]             wp;
        logic [PW-1:0]             rp;
        logic [CW-1:0]             cnt;
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][DW-1:0]  data;
        logic [DEPTH-1:0][BW-1:0]  be;
    } fifo_st_t;

    fifo_st_t q, d;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        // The drain is applied first, so a full queue can free the
        // head slot and refill it in the same cycle.
        if (pop) begin
            d.vld[q.rp] = 1'b0;
            d.rp        = nxt(q.rp);
        end
        if (push) begin
            d.vld[q.wp]  = 1'b1;
            d.addr[q.wp] = in_addr;
            d.data[q.wp] = in_data;
            d.be[q.wp]   = in_be;
            d.wp         = nxt(q.wp);
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid  = (q.cnt != '0);
    assign out_addr   = q.addr[q.rp];
    assign out_data   = q.data[q.rp];
    assign out_be     = q.be[q.rp];
    assign full       = (q.cnt == CW'(DEPTH));
    assign empty      = (q.cnt == '0);
    assign empty_next = (d.cnt == '0);
    assign slot_vld   = q.vld;
    assign slot_addr  = q.addr;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R1
    slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.vld) == int'(q.cnt));

endmodule

// File: rtl/stwb_admit.sv
module stwb_admit (
    input  logic       st_valid,
    input  logic [1:0] st_attr,
    input  logic       full,
    input  logic       pop,
    input  logic       sync_busy,
    output logic       push,
    output logic       stall
);
    import stwb_pkg::*;

    logic posted;
    logic blocked;

    always_comb begin
        posted  = st_valid && attr_posted(st_attr);
        // A full queue frees a slot only when its head drains this cycle.
        blocked = sync_busy || (full && !pop);
        stall   = posted && blocked;
        push    = posted && !blocked;
    end

endmodule

// File: rtl/stwb_sync.sv
module stwb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic empty_next,
    input  logic empty,
    output logic busy,
    output logic ack
);
    typedef struct packed {
        logic pend;
        logic ack;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d.pend = q.pend | sync_req;
        d.ack  = 1'b0;
        if (d.pend && empty_next) begin
            d.ack  = 1'b1;
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.pend;
    assign ack  = q.ack;

    // R5
    sync_ack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> empty);

endmodule

// File: rtl/stwb_match.sv
module stwb_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32
) (
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic [DEPTH-1:0]         slot_vld,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    output logic                     ld_stall
);
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = slot_vld[i] && (slot_addr[i] == ld_addr);
    end

    assign ld_stall = ld_valid && (|hit);

endmodule

// File: rtl/stwb_top.sv
module stwb_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [1:0]    st_attr,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    output logic          st_stall,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_stall,
    input  logic          sync_req,
    output logic          sync_ack,
    output logic          mw_valid,
    output logic [AW-1:0] mw_addr,
    output logic [DW-1:0] mw_data,
    output logic [BW-1:0] mw_be,
    input  logic          mw_ready
);
    logic                     push, pop, full, empty, empty_next, sync_busy;
    logic [DEPTH-1:0]         slot_vld;
    logic [DEPTH-1:0][AW-1:0] slot_addr;

    assign pop = mw_valid && mw_ready;

    stwb_admit u_admit (
        .st_valid  (st_valid),
        .st_attr   (st_attr),
        .full      (full),
        .pop       (pop),
        .sync_busy (sync_busy),
        .push      (push),
        .stall     (st_stall)
    );

    stwb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .in_addr    (st_addr),
        .in_data    (st_data),
        .in_be      (st_be),
        .pop        (pop),
        .out_valid  (mw_valid),
        .out_addr   (mw_addr),
        .out_data   (mw_data),
        .out_be     (mw_be),
        .full       (full),
        .empty      (empty),
        .empty_next (empty_next),
        .slot_vld   (slot_vld),
        .slot_addr  (slot_addr)
    );

    stwb_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req   (sync_req),
        .empty_next (empty_next),
        .empty      (empty),
        .busy       (sync_busy),
        .ack        (sync_ack)
    );

    stwb_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .ld_stall  (ld_stall)
    );

    // R10
    mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=>
            (mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_be)));

    // R8
    ld_stall_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> mw_valid);

endmodule

// File: tb/sim_stwb_top.sv
module sim_stwb_top;
    localparam int CLK_P = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int PL = AW + DW + BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [1:0]    st_attr = 2'b00;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic          st_stall;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_stall;
    logic          sync_req = 1'b0;
    logic          sync_ack;
    logic          mw_valid;
    logic [AW-1:0] mw_addr;
    logic [DW-1:0] mw_data;
    logic [BW-1:0] mw_be;
    logic          mw_ready = 1'b0;

    stwb_top #(.DEPTH(4), .AW(AW), .DW(DW), .BW(BW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_attr(st_attr), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
        .sync_req(sync_req), .sync_ack(sync_ack),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_be(mw_be), .mw_ready(mw_ready)
    );

    always #(CLK_P / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_wr  = 0;
    int n_ack = 0;
    logic [PL-1:0] exp_q[$];
    logic          hold = 1'b0;
    logic [PL-1:0] held = '0;

    task automatic chk(input string tag, input logic [PL-1:0] act, input logic [PL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic posted(input logic [1:0] a);
        return (a == 2'b01) || (a == 2'b10);
    endfunction

    // Write port monitor: a handshake seen here completes at the next rising edge.
    always begin
        @(negedge clk);
        #(CLK_P / 4);
        if (rst_n) begin
            if (hold) begin
                chk("R10 valid held", mw_valid, 1);
                chk("R10 payload held", {mw_addr, mw_data, mw_be}, held);
            end
            if (mw_valid && mw_ready) begin
                n_wr++;
                if (exp_q.size() == 0)
                    chk("R4 unexpected write", {mw_addr, mw_data, mw_be}, {PL{1'bx}});
                else
                    chk("R4 write order and content", {mw_addr, mw_data, mw_be}, exp_q.pop_front());
            end
            hold = mw_valid && !mw_ready;
            held = {mw_addr, mw_data, mw_be};
        end
    end

    // Sync acknowledge monitor
    always begin
        @(negedge clk);
        #1;
        if (rst_n && sync_ack) begin
            n_ack++;
            chk("R5 ack with stores pending", exp_q.size(), 0);
            chk("R5 ack with write valid", mw_valid, 0);
        end
    end

    task automatic do_store(input logic [1:0] attr, input logic [AW-1:0] a,
                            input logic [DW-1:0] dt, input logic [BW-1:0] be,
                            input logic rdy, output int waits);
        @(negedge clk);
        mw_ready = rdy;
        st_valid = 1'b1; st_attr = attr; st_addr = a; st_data = dt; st_be = be;
        waits = 0;
        forever begin
            #(CLK_P / 4);
            if (!st_stall) break;
            waits++;
            @(negedge clk);
        end
        if (posted(attr)) exp_q.push_back({a, dt, be});
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic wait_empty();
        @(negedge clk);
        mw_ready = 1'b1;
        for (int i = 0; i < 50; i++) begin
            #(CLK_P / 4);
            if (!mw_valid) break;
            @(negedge clk);
        end
        chk("R4 queue drained", mw_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = '0;
        #(CLK_P / 4);
        chk("R9 mw_valid after reset", mw_valid, 0);
        chk("R9 sync_ack after reset", sync_ack, 0);
        chk("R9 st_stall after reset", st_stall, 0);
        chk("R9 ld_stall after reset", ld_stall, 0);
        ld_valid = 1'b0;
    endtask

    task automatic t_fill();
        int w;
        int base;
        base = n_wr;
        for (int i = 0; i < 4; i++) begin
            do_store(2'b10, 32'h100 + 4 * i, 32'hA000 + i, 4'hF, 1'b0, w);
            chk("R1 store taken below depth", w, 0);
        end
        @(negedge clk);
        st_valid = 1'b1; st_attr = 2'b10; st_addr = 32'h200; st_data = 32'hB0; st_be = 4'h3;
        #(CLK_P / 4);
        chk("R6 stall when full", st_stall, 1);
        chk("R1 fifth store stalled", st_stall, 1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            #(CLK_P / 4);
            chk("R6 stall persists", st_stall, 1);
        end
        @(negedge clk);
        mw_ready = 1'b1;
        #(CLK_P / 4);
        chk("R7 accept on drain when full", st_stall, 0);
        exp_q.push_back({32'h200, 32'hB0, 4'h3});
        @(negedge clk);
        mw_ready = 1'b0;
        st_addr = 32'h204; st_data = 32'hB1;
        #(CLK_P / 4);
        chk("R7 queue still full", st_stall, 1);
        st_valid = 1'b0;
        wait_empty();
        chk("R6 no store dropped", n_wr - base, 5);
    endtask

    task automatic t_filter();
        int w;
        int base;
        base = n_wr;
        for (int i = 0; i < 4; i++)
            do_store(2'b01, 32'h240 + 4 * i, 32'hC0 + i, 4'h1 << i, 1'b0, w);
        do_store(2'b00, 32'h280, 32'hDEAD, 4'hF, 1'b0, w);
        chk("R2 write-back not stalled when full", w, 0);
        do_store(2'b11, 32'h284, 32'hBEEF, 4'hF, 1'b0, w);
        chk("R2 reserved not stalled when full", w, 0);
        wait_empty();
        chk("R2 only posted stores written", n_wr - base, 4);
        do_store(2'b00, 32'h290, 32'h1, 4'hF, 1'b1, w);
        do_store(2'b11, 32'h294, 32'h2, 4'hF, 1'b1, w);
        @(negedge clk);
        #(CLK_P / 4);
        chk("R2 no write from ignored stores", mw_valid, 0);
        chk("R2 ignored stores give no write count", n_wr - base, 4);
    endtask

    task automatic t_wthru();
        int w;
        int base;
        base = n_wr;
        for (int i = 0; i < 3; i++)
            do_store(2'b01, 32'h300, 32'h5000 + i, 4'hF, 1'b1, w);
        do_store(2'b00, 32'h300, 32'h6000, 4'hF, 1'b1, w);
        wait_empty();
        chk("R3 one write per write-through store", n_wr - base, 3);
    endtask

    task automatic t_order();
        int w;
        int base;
        base = n_wr;
        for (int i = 0; i < 8; i++)
            do_store((i % 3 == 0) ? 2'b01 : 2'b10, 32'h400 + 8 * i, 32'h7700 + 3 * i,
                     4'(i + 1), 1'(i % 2), w);
        wait_empty();
        chk("R4 all ordered writes seen", n_wr - base, 8);
    endtask

    task automatic t_load();
        int w;
        do_store(2'b10, 32'h500, 32'h11, 4'hF, 1'b0, w);
        do_store(2'b01, 32'h504, 32'h22, 4'hF, 1'b0, w);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 32'h500;
        #(CLK_P / 4);
        chk("R8 load hits head entry", ld_stall, 1);
        @(negedge clk);
        ld_addr = 32'h508;
        #(CLK_P / 4);
        chk("R8 load to other address", ld_stall, 0);
        @(negedge clk);
        ld_addr = 32'h504;
        #(CLK_P / 4);
        chk("R8 load hits second entry", ld_stall, 1);
        @(negedge clk);
        ld_addr = 32'h500; mw_ready = 1'b1;
        #(CLK_P / 4);
        chk("R8 stall until handshake", ld_stall, 1);
        @(negedge clk);
        mw_ready = 1'b0;
        #(CLK_P / 4);
        chk("R8 stall clears after drain", ld_stall, 0);
        @(negedge clk);
        ld_addr = 32'h504;
        #(CLK_P / 4);
        chk("R8 remaining entry still stalls", ld_stall, 1);
        ld_valid = 1'b0;
        wait_empty();
    endtask

    task automatic t_sync_empty();
        int base;
        base = n_ack;
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        #(CLK_P / 4);
        chk("R11 ack one cycle after request", sync_ack, 1);
        @(negedge clk);
        #(CLK_P / 4);
        chk("R11 ack is a single pulse", sync_ack, 0);
        chk("R11 one ack counted", n_ack - base, 1);
    endtask

    task automatic t_sync_full();
        int w;
        int base;
        int seen;
        base = n_ack;
        seen = 0;
        for (int i = 0; i < 3; i++)
            do_store(2'b10, 32'h600 + 4 * i, 32'h9900 + i, 4'hF, 1'b0, w);
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #(CLK_P / 4);
            chk("R5 no ack while stores queued", sync_ack, 0);
            @(negedge clk);
        end
        st_valid = 1'b1; st_attr = 2'b01; st_addr = 32'h700; st_data = 32'h77; st_be = 4'hF;
        #(CLK_P / 4);
        chk("R5 store held during sync", st_stall, 1);
        st_valid = 1'b0;
        @(negedge clk);
        mw_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #(CLK_P / 4);
            if (sync_ack) begin
                seen = 1;
                chk("R5 ack only after drain", exp_q.size(), 0);
            end
            @(negedge clk);
        end
        chk("R5 ack observed", seen, 1);
        chk("R5 exactly one ack", n_ack - base, 1);
    endtask

    task automatic t_random();
        logic          have;
        logic [1:0]    ra;
        logic [AW-1:0] rad;
        logic [DW-1:0] rdt;
        logic [BW-1:0] rbe;
        have = 1'b0; ra = '0; rad = '0; rdt = '0; rbe = '0;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            mw_ready = ($urandom_range(0, 3) != 0);
            sync_req = ($urandom_range(0, 19) == 0);
            if (!have && ($urandom_range(0, 2) != 0)) begin
                have = 1'b1;
                ra  = 2'($urandom_range(0, 3));
                rad = 32'h800 + 32'(4 * $urandom_range(0, 7));
                rdt = $urandom;
                rbe = 4'($urandom_range(0, 15));
            end
            st_valid = have; st_attr = ra; st_addr = rad; st_data = rdt; st_be = rbe;
            #(CLK_P / 4);
            if (have && !st_stall) begin
                if (posted(ra)) exp_q.push_back({rad, rdt, rbe});
                have = 1'b0;
            end
        end
        @(negedge clk);
        st_valid = 1'b0; sync_req = 1'b0;
        wait_empty();
        chk("R4 random traffic fully written", exp_q.size(), 0);
        t_sync_empty();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_filter();
        t_wthru();
        t_order();
        t_load();
        t_sync_empty();
        t_sync_full();
        t_random();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule